// File: doc/BRIEF.md
# Banked Register File with Byte, Word and Pair Views

This block is the architectural register storage of a small 16-bit controller core. It holds four general data registers, two address registers, a frame base, a static base, an interrupt table base and two physical stack pointers (one for user context, one for interrupt context). Logic outside the block refers to this storage through a 5-bit view code. A view code selects one of three things: a whole 16-bit register, one 8-bit half of the first two data registers, or a 32-bit register formed by joining two registers.

There is one write port and two read ports, and all of them are synchronous. A write takes effect at the clock edge at which `wr_en` is sampled high. Each read port registers its result, so read data appears one edge after the view code is presented. A context input, `stk_sel`, chooses which stack pointer copy the stack view reaches. A view code with no meaning raises an error flag and changes no register. These ports carry register selections, not a data stream, so there is no valid/ready handshake. A write is accepted on every cycle in which `wr_en` is high, and each read port returns a result on every cycle.

The view codes are: 0 D0, 1 D1, 2 D2, 3 D3, 4 X0, 5 X1, 6 frame base, 7 static base, 8 interrupt table base, 9 stack pointer (banked), 10 D0 low byte, 11 D0 high byte, 12 D1 low byte, 13 D1 high byte, 14 pair D2:D0, 15 pair D3:D1, 16 pair X1:X0. Codes 17 to 31 are illegal. D2 and D3 have no byte codes.

Top module: `regv_regfile`

## Requirements
- R1: After reset every register, including both stack pointer copies, reads as zero, and `wr_err`, `rd_a_err` and `rd_b_err` are low.
- R2: Word views (codes 0 to 9) write all 16 bits of the register from `wr_data[15:0]`. A word read returns the register in bits 15:0 with bits 31:16 zero.
- R3: A byte write (code 10 D0 low, 11 D0 high, 12 D1 low, 13 D1 high) takes its data from `wr_data[7:0]`. It changes only the selected half and leaves the other half of the register unchanged.
- R4: A byte read returns the selected half in bits 7:0, with bits 31:8 zero.
- R5: In a pair view (code 14 D2:D0, 15 D3:D1, 16 X1:X0), the first-named register maps to bits 31:16 and the second-named register maps to bits 15:0. A pair write updates both registers from `wr_data[31:0]`.
- R6: The stack view (code 9) reaches the user copy when `stk_sel` is 0 and the interrupt copy when `stk_sel` is 1. The other copy is never touched.
- R7: A write with a code from 17 to 31 changes no register, and `wr_err` is high in the cycle after it. `wr_err` is low in the cycle after any legal write or any idle cycle.
- R8: A read with a code from 17 to 31 returns zero data and sets that port's error flag in the cycle after it. A legal view code clears the flag.
- R9: Read data is valid one edge after the view code is presented. A read issued in the same cycle as a write to the same register returns the old value. A read issued in the next cycle returns the new value.
- R10: The two read ports are independent: each one returns its own view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stk_sel | input | 1 | Stack pointer bank: 0 user, 1 interrupt |
| wr_en | input | 1 | Write strobe |
| wr_view | input | 5 | View code of the write |
| wr_data | input | 32 | Write data (word uses 15:0, byte uses 7:0, pair uses 31:0) |
| wr_err | output | 1 | Previous cycle's write used an illegal code |
| rd_a_view | input | 5 | View code for read port A |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_a_err | output | 1 | Port A view was illegal |
| rd_b_view | input | 5 | View code for read port B |
| rd_b_data | output | 32 | Registered read data, port B |
| rd_b_err | output | 1 | Port B view was illegal |

## Verification
Each result of this block arrives exactly one rising edge after its stimulus. This holds for read data, read error flags and the write error flag. New register contents become readable by a read presented in the cycle after the write. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, which is half a period after the result's edge. In the same-cycle read/write test it samples first at that edge, where the old value is expected, and then one cycle later, where the new value is expected. To check that an illegal write changed nothing, the bench reads back every legal view through both ports and compares each one with a model kept from the requirements.

// File: rtl/regv_pkg.sv
package regv_pkg;
  localparam int VIEW_W = 5;
  localparam int NPHYS  = 11;
  localparam int IDX_W  = $clog2(NPHYS);

  // physical storage slots
  localparam logic [IDX_W-1:0] P_D0   = 4'd0;
  localparam logic [IDX_W-1:0] P_D1   = 4'd1;
  localparam logic [IDX_W-1:0] P_D2   = 4'd2;
  localparam logic [IDX_W-1:0] P_D3   = 4'd3;
  localparam logic [IDX_W-1:0] P_X0   = 4'd4;
  localparam logic [IDX_W-1:0] P_X1   = 4'd5;
  localparam logic [IDX_W-1:0] P_USTK = 4'd9;
  localparam logic [IDX_W-1:0] P_ISTK = 4'd10;

  typedef enum logic [VIEW_W-1:0] {
    V_D0 = 5'd0, V_D1 = 5'd1, V_D2 = 5'd2, V_D3 = 5'd3,
    V_X0 = 5'd4, V_X1 = 5'd5, V_FRM = 5'd6, V_STB = 5'd7,
    V_ITB = 5'd8, V_STK = 5'd9,
    V_D0L = 5'd10, V_D0H = 5'd11, V_D1L = 5'd12, V_D1H = 5'd13,
    V_P20 = 5'd14, V_P31 = 5'd15, V_PX = 5'd16
  } view_e;

  typedef enum logic [1:0] {K_NONE, K_WORD, K_BYTE, K_PAIR} kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
    logic             byte_hi;
  } sel_t;
endpackage

// File: rtl/regv_view_decode.sv
module regv_view_decode
  import regv_pkg::*;
(
  input  logic [VIEW_W-1:0] view,
  input  logic              stk_sel,
  output sel_t              sel
);
  always_comb begin
    sel = '{kind: K_NONE, lo: '0, hi: '0, byte_hi: 1'b0};
    case (view_e'(view))
      V_D0, V_D1, V_D2, V_D3, V_X0, V_X1, V_FRM, V_STB, V_ITB: begin
        sel.kind = K_WORD;
        sel.lo   = view[IDX_W-1:0];
      end
      V_STK: begin
        sel.kind = K_WORD;
        sel.lo   = stk_sel ? P_ISTK : P_USTK;
      end
      V_D0L: begin sel.kind = K_BYTE; sel.lo = P_D0; sel.byte_hi = 1'b0; end
      V_D0H: begin sel.kind = K_BYTE; sel.lo = P_D0; sel.byte_hi = 1'b1; end
      V_D1L: begin sel.kind = K_BYTE; sel.lo = P_D1; sel.byte_hi = 1'b0; end
      V_D1H: begin sel.kind = K_BYTE; sel.lo = P_D1; sel.byte_hi = 1'b1; end
      V_P20: begin sel.kind = K_PAIR; sel.hi = P_D2; sel.lo = P_D0; end
      V_P31: begin sel.kind = K_PAIR; sel.hi = P_D3; sel.lo = P_D1; end
      V_PX:  begin sel.kind = K_PAIR; sel.hi = P_X1; sel.lo = P_X0; end
      default: sel.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/regv_store.sv
module regv_store
  import regv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  sel_t                       sel,
  input  logic [2*DW-1:0]            wdata,
  output logic [NPHYS-1:0][DW-1:0]   regs_q
);
  localparam int HB = DW / 2;

  for (genvar i = 0; i < NPHYS; i++) begin : g_reg
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    logic [DW-1:0] nxt;

    always_comb begin
      nxt = regs_q[i];
      if (we) begin
        case (sel.kind)
          K_WORD: if (sel.lo == ME) nxt = wdata[DW-1:0];
          K_BYTE: if (sel.lo == ME) begin
            if (sel.byte_hi) nxt[DW-1:HB] = wdata[HB-1:0];
            else             nxt[HB-1:0]  = wdata[HB-1:0];
          end
          K_PAIR: begin
            if (sel.lo == ME) nxt = wdata[DW-1:0];
            if (sel.hi == ME) nxt = wdata[2*DW-1:DW];
          end
          default: nxt = regs_q[i];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/regv_read_port.sv
module regv_read_port
  import regv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sel_t                     sel,
  input  logic [NPHYS-1:0][DW-1:0] regs,
  output logic [2*DW-1:0]          rdata,
  output logic                     err
);
  localparam int HB = DW / 2;
  logic [2*DW-1:0] nxt;
  logic [DW-1:0]   lo_w;

  assign lo_w = regs[sel.lo];

  always_comb begin
    nxt = '0;
    case (sel.kind)
      K_WORD: nxt[DW-1:0] = lo_w;
      K_BYTE: nxt[HB-1:0] = sel.byte_hi ? lo_w[DW-1:HB] : lo_w[HB-1:0];
      K_PAIR: nxt = {regs[sel.hi], lo_w};
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= nxt;
      err   <= (sel.kind == K_NONE);
    end
  end
endmodule

// File: rtl/regv_regfile.sv
module regv_regfile
  import regv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stk_sel,
  input  logic              wr_en,
  input  logic [VIEW_W-1:0] wr_view,
  input  logic [2*DW-1:0]   wr_data,
  output logic              wr_err,
  input  logic [VIEW_W-1:0] rd_a_view,
  output logic [2*DW-1:0]   rd_a_data,
  output logic              rd_a_err,
  input  logic [VIEW_W-1:0] rd_b_view,
  output logic [2*DW-1:0]   rd_b_data,
  output logic              rd_b_err
);
  localparam int NRD = 2;

  sel_t                     wsel;
  logic [NPHYS-1:0][DW-1:0] regs;
  logic [NRD-1:0][VIEW_W-1:0] rview;
  logic [NRD-1:0][2*DW-1:0]   rdat;
  logic [NRD-1:0]             rerr;

  regv_view_decode u_wdec (.view(wr_view), .stk_sel(stk_sel), .sel(wsel));

  regv_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .sel(wsel),
    .wdata(wr_data), .regs_q(regs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_en && (wsel.kind == K_NONE);
  end

  assign rview[0] = rd_a_view;
  assign rview[1] = rd_b_view;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    sel_t rsel;
    regv_view_decode u_rdec (.view(rview[p]), .stk_sel(stk_sel), .sel(rsel));
    regv_read_port #(.DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n), .sel(rsel), .regs(regs),
      .rdata(rdat[p]), .err(rerr[p])
    );
  end

  assign rd_a_data = rdat[0];
  assign rd_a_err  = rerr[0];
  assign rd_b_data = rdat[1];
  assign rd_b_err  = rerr[1];
endmodule

// File: rtl/regv_regfile_chk.sv
module regv_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_view,
  input logic [31:0] wr_data,
  input logic        wr_err,
  input logic [4:0]  rd_a_view,
  input logic [31:0] rd_a_data,
  input logic        rd_a_err
);
  // R7
  illegal_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view > 5'd16) |=> wr_err);

  // R7
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_view > 5'd16) |=> !wr_err);

  // R8
  illegal_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_view > 5'd16) |=> (rd_a_err && rd_a_data == 32'd0));

  // R4
  byte_rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_view >= 5'd10 && rd_a_view <= 5'd13) |=> (rd_a_data[31:8] == 24'd0 && !rd_a_err));

  // R2
  word_rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_view <= 5'd9) |=> (rd_a_data[31:16] == 16'd0 && !rd_a_err));

  // R9
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view == 5'd2) ##1 (rd_a_view == 5'd2 && !wr_en)
      |=> rd_a_data[15:0] == $past(wr_data[15:0], 2));

  // R5
  pair_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view == 5'd16) ##1 (rd_a_view == 5'd16 && !wr_en)
      |=> rd_a_data == $past(wr_data, 2));
endmodule

bind regv_regfile regv_regfile_chk u_chk (.*);

// File: tb/regv_regfile_test.sv
module regv_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stk_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_view = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic [4:0]  rd_a_view = '0;
  logic [31:0] rd_a_data;
  logic        rd_a_err;
  logic [4:0]  rd_b_view = '0;
  logic [31:0] rd_b_data;
  logic        rd_b_err;

  int errors = 0;
  int checks = 0;
  logic [15:0] m [11];

  always #5 clk = ~clk;

  regv_regfile uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [4:0] v, input logic s);
    logic [31:0] r = '0;
    if (v <= 5'd8)        r[15:0] = m[v];
    else if (v == 5'd9)   r[15:0] = s ? m[10] : m[9];
    else if (v == 5'd10)  r[7:0]  = m[0][7:0];
    else if (v == 5'd11)  r[7:0]  = m[0][15:8];
    else if (v == 5'd12)  r[7:0]  = m[1][7:0];
    else if (v == 5'd13)  r[7:0]  = m[1][15:8];
    else if (v == 5'd14)  r = {m[2], m[0]};
    else if (v == 5'd15)  r = {m[3], m[1]};
    else if (v == 5'd16)  r = {m[5], m[4]};
    return r;
  endfunction

  function automatic void model_wr(input logic [4:0] v, input logic [31:0] d, input logic s);
    if (v <= 5'd8)        m[v] = d[15:0];
    else if (v == 5'd9)   begin if (s) m[10] = d[15:0]; else m[9] = d[15:0]; end
    else if (v == 5'd10)  m[0][7:0]  = d[7:0];
    else if (v == 5'd11)  m[0][15:8] = d[7:0];
    else if (v == 5'd12)  m[1][7:0]  = d[7:0];
    else if (v == 5'd13)  m[1][15:8] = d[7:0];
    else if (v == 5'd14)  begin m[2] = d[31:16]; m[0] = d[15:0]; end
    else if (v == 5'd15)  begin m[3] = d[31:16]; m[1] = d[15:0]; end
    else if (v == 5'd16)  begin m[5] = d[31:16]; m[4] = d[15:0]; end
  endfunction

  task automatic wr(input logic [4:0] v, input logic [31:0] d, input logic s, output logic err);
    @(negedge clk);
    wr_en = 1'b1; wr_view = v; wr_data = d; stk_sel = s;
    @(negedge clk);
    err = wr_err;
    wr_en = 1'b0;
    model_wr(v, d, s);
  endtask

  task automatic rd(input logic [4:0] va, input logic [4:0] vb, input logic s,
                    output logic [31:0] da, output logic ea,
                    output logic [31:0] db, output logic eb);
    @(negedge clk);
    rd_a_view = va; rd_b_view = vb; stk_sel = s;
    @(negedge clk);
    da = rd_a_data; ea = rd_a_err; db = rd_b_data; eb = rd_b_err;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] va, input logic [4:0] vb, input logic s);
    logic [31:0] da, db; logic ea, eb;
    rd(va, vb, s, da, ea, db, eb);
    check({tag, " port A data"}, da, model_rd(va, s));
    check({tag, " port A err"}, {31'd0, ea}, 32'd0);
    check({tag, " port B data"}, db, model_rd(vb, s));
    check({tag, " port B err"}, {31'd0, eb}, 32'd0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 11; i++) m[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 wr_err after reset", {31'd0, wr_err}, 32'd0);
    for (int v = 0; v <= 16; v++) rd_check("R1 reset zero", 5'(v), 5'(16 - v), 1'b0);
    rd_check("R1 reset zero interrupt stack", 5'd9, 5'd9, 1'b1);
  endtask

  task automatic t_word();
    logic e;
    for (int v = 0; v <= 8; v++) begin
      wr(5'(v), 32'hDEAD_0000 | (32'hA0C0 + 32'(v) * 32'h0111), 1'b0, e);
      check("R2 legal word write no err", {31'd0, e}, 32'd0);
    end
    for (int v = 0; v <= 8; v++) rd_check("R2/R10 word readback", 5'(v), 5'(8 - v), 1'b0);
  endtask

  task automatic t_byte();
    logic e;
    wr(5'd10, 32'hFFFF_FF5A, 1'b0, e);
    wr(5'd13, 32'h0000_00C3, 1'b0, e);
    rd_check("R3 byte write keeps other half", 5'd0, 5'd1, 1'b0);
    rd_check("R4 byte read", 5'd11, 5'd12, 1'b0);
    rd_check("R4 byte read", 5'd10, 5'd13, 1'b0);
    check("R3 D0 expect", model_rd(5'd0, 1'b0), {16'd0, 8'hA0 + 8'h00, 8'h5A});
  endtask

  task automatic t_pair();
    logic e;
    wr(5'd14, 32'h1234_5678, 1'b0, e);
    wr(5'd15, 32'h9ABC_DEF0, 1'b0, e);
    wr(5'd16, 32'h0F1E_2D3C, 1'b0, e);
    rd_check("R5 pair read", 5'd14, 5'd15, 1'b0);
    rd_check("R5 pair read", 5'd16, 5'd2, 1'b0);
    rd_check("R5 pair halves", 5'd4, 5'd5, 1'b0);
    rd_check("R5 pair halves", 5'd0, 5'd3, 1'b0);
  endtask

  task automatic t_stack();
    logic e;
    wr(5'd9, 32'h0000_1000, 1'b0, e);
    wr(5'd9, 32'h0000_2000, 1'b1, e);
    rd_check("R6 user stack", 5'd9, 5'd6, 1'b0);
    rd_check("R6 interrupt stack", 5'd9, 5'd7, 1'b1);
    check("R6 user copy kept", model_rd(5'd9, 1'b0), 32'h0000_1000);
  endtask

  task automatic t_illegal_wr();
    logic e;
    wr(5'd17, 32'hFFFF_FFFF, 1'b0, e);
    check("R7 wr_err code 17", {31'd0, e}, 32'd1);
    wr(5'd23, 32'hFFFF_FFFF, 1'b1, e);
    check("R7 wr_err code 23", {31'd0, e}, 32'd1);
    wr(5'd31, 32'hFFFF_FFFF, 1'b0, e);
    check("R7 wr_err code 31", {31'd0, e}, 32'd1);
    for (int v = 0; v <= 16; v++) rd_check("R7 nothing changed", 5'(v), 5'(v), 1'b0);
    rd_check("R7 nothing changed interrupt stack", 5'd9, 5'd9, 1'b1);
    wr(5'd7, 32'h0000_7777, 1'b0, e);
    check("R7 wr_err clears", {31'd0, e}, 32'd0);
  endtask

  task automatic t_illegal_rd();
    logic [31:0] da, db; logic ea, eb;
    rd(5'd17, 5'd0, 1'b0, da, ea, db, eb);
    check("R8 illegal read data", da, 32'd0);
    check("R8 illegal read err", {31'd0, ea}, 32'd1);
    check("R10 other port unaffected", db, model_rd(5'd0, 1'b0));
    check("R10 other port err", {31'd0, eb}, 32'd0);
    rd(5'd14, 5'd31, 1'b0, da, ea, db, eb);
    check("R8 illegal read B data", db, 32'd0);
    check("R8 illegal read B err", {31'd0, eb}, 32'd1);
    check("R8 port A clears err", {31'd0, ea}, 32'd0);
    check("R10 port A pair", da, model_rd(5'd14, 1'b0));
  endtask

  task automatic t_same_cycle();
    logic [31:0] old;
    old = model_rd(5'd3, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_view = 5'd3; wr_data = 32'h0000_BEEF; stk_sel = 1'b0;
    rd_a_view = 5'd3; rd_b_view = 5'd15;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 same-cycle read old", rd_a_data, old);
    model_wr(5'd3, 32'h0000_BEEF, 1'b0);
    @(negedge clk);
    check("R9 next-cycle read new", rd_a_data, 32'h0000_BEEF);
    check("R9 pair sees new high", rd_b_data, model_rd(5'd15, 1'b0));
  endtask

  initial begin
    t_reset();
    t_word();
    t_byte();
    t_pair();
    t_stack();
    t_illegal_wr();
    t_illegal_rd();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule